// File: doc/BRIEF.md
# Serial EEPROM-style I2C slave engine

This block is the protocol side of a byte-addressed serial memory on an I2C bus. It samples the bus clock and data lines with the system clock and recognises START, repeated START and STOP. It shifts in a select byte and checks it against a fixed device-type nibble and three hardware strap inputs. It then either takes a two-byte memory address followed by write data, or returns read data by pulling SDA low through an open-drain enable. Storage is outside the block. The block drives a plain RAM port (address, write data, one-cycle write strobe, combinational read data) into a page buffer. It raises a one-cycle commit strobe when a write transaction closes.

The address counter is `ADDR_W` bits wide. Set it to 13 or 12 to ignore the three or four top bits of the 16-bit address. Writes stay inside a page of 2^`PAGE_W` bytes. A write-inhibit input, seen at any cycle of the command header, blocks the data phase of that write. Reads are not affected by it. Clock stretching and the busy period of a nonvolatile programming cycle are not modelled.

States: `ST_IDLE` (bus ignored until START), `ST_DEV` (select byte in), `ST_DEV_ACK`, `ST_AHI` (address high byte in), `ST_AHI_ACK`, `ST_ALO` (address low byte in), `ST_ALO_ACK`, `ST_WDAT` (write byte in), `ST_WACK`, `ST_RDAT` (read byte out), `ST_RACK` (master acknowledge in).

Transitions:
- START from any state goes to `ST_DEV`. STOP from any state goes to `ST_IDLE`.
- At the end of the select byte, `ST_DEV` goes to `ST_DEV_ACK` on a match and to `ST_IDLE` otherwise.
- `ST_DEV_ACK` goes to `ST_RDAT` for a read and to `ST_AHI` for a write.
- The header runs `ST_AHI`, then `ST_AHI_ACK`, then `ST_ALO`, then `ST_ALO_ACK`, then `ST_WDAT`.
- Write data loops between `ST_WDAT` and `ST_WACK`.
- Read data loops between `ST_RDAT` and `ST_RACK` while the master acknowledges. After a master NoAck, `ST_RACK` goes to `ST_IDLE`.

Top module: `sermem_slave`

## Requirements
- R1: The select byte is received MSB first as {1010, strap[2:0], RW}. The slave acknowledges it (SDA pulled low during the ninth clock) only when the top nibble is 1010 and bits 3..1 equal `strap_addr`.
- R2: After a select byte that does not match, the slave never pulls SDA low and issues no write until the next START.
- R3: For RW=0, two address bytes follow, high byte first, and each is acknowledged. Address bits at and above `ADDR_W` are ignored, so `ram_addr` carries only the low `ADDR_W` bits.
- R4: With writes allowed, each data byte is acknowledged and written with a one-cycle `ram_we` at the current address. The address then advances inside its page: the low `PAGE_W` bits wrap and the upper bits are held.
- R5: If `wr_inhibit` is high in any cycle from START until the second address byte is complete, the data bytes of that write get NoAck. That write then raises no `ram_we` and no commit.
- R6: A random read is a select byte with RW=0 and two address bytes, then a repeated START and a select byte with RW=1. The first returned byte is the one at the loaded address.
- R7: A select byte with RW=1 straight after START returns the byte at the address counter. The counter advances by one over the whole array after every byte read, and read data does not depend on `wr_inhibit`.
- R8: Reading continues while the master acknowledges each byte. After a master NoAck, the slave releases SDA and stays off the bus until the next START.
- R9: A STOP that closes a transaction with at least one written byte gives a one-cycle `commit`. A STOP after a read, a dummy write or an inhibited write gives none.
- R10: `sda_pull` starts pulling SDA only while the synchronized SCL is low. SDA edges while SCL is high are taken as START (falling) or STOP (rising).
- R11: During and after reset, `sda_pull`, `ram_we` and `commit` are low and the address counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_addr | input | 3 | Hardware address straps matched against select bits 3..1 |
| wr_inhibit | input | 1 | High blocks the data phase of a write |
| ram_addr | output | ADDR_W | Page buffer address (address counter) |
| ram_wdata | output | 8 | Page buffer write data |
| ram_we | output | 1 | One-cycle page buffer write strobe |
| ram_rdata | input | 8 | Page buffer read data for `ram_addr` |
| commit | output | 1 | One-cycle strobe: written page may be programmed |

## Verification
A wrong state shows up at the ninth clock of the byte in which it arises. The slave gives an acknowledge where none is due, or leaves one out, and the master model samples that in the middle of the same SCL high phase. A wrong address counter shows as a mismatched `ram_addr` on the next `ram_we`, or as a wrong read byte one byte later. A wrongly latched inhibit shows as a write strobe the reference queue does not expect, in the cycle after the data byte ends. A lost or extra commit appears in the cycle after STOP is detected.

// File: rtl/sermem_pkg.sv
`timescale 1ns/1ps
package sermem_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } sm_state_t;

endpackage

// File: rtl/sermem_buscond.sv
`timescale 1ns/1ps
// Synchronises the two bus lines and derives edge and condition events.
module sermem_buscond #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);

    logic [SYNC_LEN-1:0] scl_pipe;
    logic [SYNC_LEN-1:0] sda_pipe;
    logic                scl_d;
    logic                sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_LEN-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_LEN-2:0], sda_i};
            scl_d    <= scl_pipe[SYNC_LEN-1];
            sda_d    <= sda_pipe[SYNC_LEN-1];
        end
    end

    assign scl_s    = scl_pipe[SYNC_LEN-1];
    assign sda_s    = sda_pipe[SYNC_LEN-1];
    assign ev_rise  = scl_s & ~scl_d;
    assign ev_fall  = ~scl_s & scl_d;
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/sermem_addr_ctr.sv
`timescale 1ns/1ps
// Byte address counter: loads a 16-bit header address, keeps ADDR_W bits,
// steps inside a page for writes and across the array for reads.
module sermem_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [15:0]       load_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] addr
);

    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] col_next;
    logic [ROW_W-1:0]  row_keep;

    assign col_next = addr[PAGE_W-1:0] + PAGE_W'(1);
    assign row_keep = addr[ADDR_W-1:PAGE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val[ADDR_W-1:0];
        end else if (step_page) begin
            addr <= {row_keep, col_next};
        end else if (step_full) begin
            addr <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/sermem_slave.sv
`timescale 1ns/1ps
module sermem_slave
    import sermem_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter int          PAGE_W   = 5,
    parameter int          SYNC_LEN = 2,
    parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic [2:0]        strap_addr,
    input  logic              wr_inhibit,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata,
    output logic              commit
);

    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    // bus events
    logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;

    sermem_buscond #(.SYNC_LEN(SYNC_LEN)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    sm_state_t        st, st_nx;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [7:0]       addr_hi;
    logic             rw;
    logic             mack;
    logic             wc_seen;
    logic             wr_pend;
    logic             drive;
    logic             we_q;
    logic [7:0]       wdata_q;
    logic             commit_q;

    logic             byte_end;
    logic             sel_ok;
    logic             rx_state;
    logic             hdr_state;
    logic             ctr_load;
    logic             ctr_step_full;

    assign byte_end  = ev_fall && (bitcnt == CNT_W'(BYTE_BITS));
    assign sel_ok    = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_addr);
    assign rx_state  = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
    assign hdr_state = (st == ST_DEV) || (st == ST_DEV_ACK) || (st == ST_AHI) ||
                       (st == ST_AHI_ACK) || (st == ST_ALO);
    assign ctr_load      = (st == ST_ALO) && byte_end && !ev_start && !ev_stop;
    assign ctr_step_full = (st == ST_RDAT) && byte_end && !ev_start && !ev_stop;

    sermem_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_val  ({addr_hi, shreg}),
        .step_page (we_q),
        .step_full (ctr_step_full),
        .addr      (ram_addr)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    begin end
            ST_DEV:     if (byte_end) st_nx = sel_ok ? ST_DEV_ACK : ST_IDLE;
            ST_DEV_ACK: if (ev_fall)  st_nx = rw ? ST_RDAT : ST_AHI;
            ST_AHI:     if (byte_end) st_nx = ST_AHI_ACK;
            ST_AHI_ACK: if (ev_fall)  st_nx = ST_ALO;
            ST_ALO:     if (byte_end) st_nx = ST_ALO_ACK;
            ST_ALO_ACK: if (ev_fall)  st_nx = ST_WDAT;
            ST_WDAT:    if (byte_end) st_nx = ST_WACK;
            ST_WACK:    if (ev_fall)  st_nx = ST_WDAT;
            ST_RDAT:    if (byte_end) st_nx = ST_RACK;
            ST_RACK:    if (ev_fall)  st_nx = mack ? ST_RDAT : ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
        if (ev_start) begin
            st_nx = ST_DEV;
        end else if (ev_stop) begin
            st_nx = ST_IDLE;
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            addr_hi  <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            wc_seen  <= 1'b0;
            wr_pend  <= 1'b0;
            drive    <= 1'b0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
            commit_q <= 1'b0;
        end else begin
            we_q     <= 1'b0;
            commit_q <= 1'b0;
            if (ev_start) begin
                bitcnt  <= '0;
                drive   <= 1'b0;
                wr_pend <= 1'b0;
                wc_seen <= wr_inhibit;
            end else if (ev_stop) begin
                bitcnt   <= '0;
                drive    <= 1'b0;
                wr_pend  <= 1'b0;
                commit_q <= wr_pend;
            end else begin
                if (hdr_state && wr_inhibit) begin
                    wc_seen <= 1'b1;
                end
                if (we_q) begin
                    wr_pend <= 1'b1;
                end
                // bit counting and receive shifting
                if (ev_rise && (rx_state || st == ST_RDAT)) begin
                    bitcnt <= bitcnt + CNT_W'(1);
                    if (rx_state) begin
                        shreg <= {shreg[6:0], sda_s};
                    end
                end else if (byte_end) begin
                    bitcnt <= '0;
                end

                unique case (st)
                    ST_IDLE: drive <= 1'b0;
                    ST_DEV: if (byte_end) begin
                        drive <= sel_ok;
                        rw    <= shreg[0];
                    end
                    ST_AHI: if (byte_end) begin
                        drive   <= 1'b1;
                        addr_hi <= shreg;
                    end
                    ST_ALO: if (byte_end) begin
                        drive <= 1'b1;
                    end
                    ST_WDAT: if (byte_end) begin
                        drive   <= !wc_seen;
                        we_q    <= !wc_seen;
                        wdata_q <= shreg;
                    end
                    ST_DEV_ACK: if (ev_fall) begin
                        if (rw) begin
                            txreg <= ram_rdata;
                            drive <= ~ram_rdata[7];
                        end else begin
                            drive <= 1'b0;
                        end
                    end
                    ST_AHI_ACK, ST_ALO_ACK, ST_WACK: if (ev_fall) begin
                        drive <= 1'b0;
                    end
                    ST_RDAT: if (ev_fall) begin
                        if (byte_end) begin
                            drive <= 1'b0;
                        end else begin
                            txreg <= {txreg[6:0], 1'b0};
                            drive <= ~txreg[6];
                        end
                    end
                    ST_RACK: begin
                        if (ev_rise) begin
                            mack <= !sda_s;
                        end
                        if (ev_fall) begin
                            if (mack) begin
                                txreg <= ram_rdata;
                                drive <= ~ram_rdata[7];
                            end else begin
                                drive <= 1'b0;
                            end
                        end
                    end
                    default: drive <= 1'b0;
                endcase
            end
        end
    end

    assign sda_pull  = drive;
    assign ram_we    = we_q;
    assign ram_wdata = wdata_q;
    assign commit    = commit_q;

endmodule

// File: rtl/sermem_slave_chk.sv
`timescale 1ns/1ps
module sermem_slave_chk
    import sermem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              ev_stop,
    input logic              sda_pull,
    input logic              ram_we,
    input logic              commit,
    input logic              wc_seen,
    input logic [ADDR_W-1:0] ram_addr,
    input sm_state_t         st
);

    // R10: the slave only starts pulling SDA while SCL is low
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R2 / R8: an idle slave is off the bus
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_pull);

    // R4: write strobe is a single-cycle pulse
    assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R4: stepping after a write keeps the page (row) bits
    assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (ram_addr[ADDR_W-1:PAGE_W] == $past(ram_addr[ADDR_W-1:PAGE_W])));

    // R5: no write while the header saw the inhibit
    assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !wc_seen);

    // R9: commit follows a detected STOP
    assert_commit_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(ev_stop));

endmodule

bind sermem_slave sermem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .ev_stop  (ev_stop),
    .sda_pull (sda_pull),
    .ram_we   (ram_we),
    .commit   (commit),
    .wc_seen  (wc_seen),
    .ram_addr (ram_addr),
    .st       (st)
);

// File: tb/sim_sermem_slave.sv
`timescale 1ns/1ps
module sim_sermem_slave;

    localparam int ADDR_W = 13;
    localparam int H      = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              wr_inhibit = 1'b0;
    logic [2:0]        strap_addr = 3'b101;
    logic              sda_pull;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic              ram_we;
    logic [7:0]        ram_rdata;
    logic              commit;
    logic              sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    sermem_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull   (sda_pull),
        .strap_addr (strap_addr),
        .wr_inhibit (wr_inhibit),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_rdata  (ram_rdata),
        .commit     (commit)
    );

    // behavioural page buffer
    logic [7:0] mem [0:1023];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
        end else if (ram_we) begin
            mem[ram_addr[9:0]] <= ram_wdata;
        end
    end
    assign ram_rdata = mem[ram_addr[9:0]];

    int n_chk = 0;
    int n_err = 0;
    int n_commit = 0;
    bit quiet = 1'b0;
    bit prev_pull = 1'b0;
    logic [20:0] wq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the expected write stream and bus rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R4/R5 unexpected write", int'(ram_addr), -1);
                end else begin
                    logic [20:0] e;
                    e = wq.pop_front();
                    check({ram_addr, ram_wdata} == e, "R4 write addr/data",
                          int'({ram_addr, ram_wdata}), int'(e));
                end
            end
            if (commit) n_commit++;
            if (quiet && sda_pull) check(1'b0, "R2/R8 drive while off bus", 1, 0);
            if (sda_pull && !prev_pull && scl_m) check(1'b0, "R10 pull with SCL high", 1, 0);
            prev_pull = sda_pull;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cyc(input logic b, output logic s);
        sda_m = b;
        waitc(H/2);
        scl_m = 1'b1;
        waitc(H/2);
        s = sda_line;
        waitc(H/2);
        scl_m = 1'b0;
        waitc(H/2);
    endtask

    task automatic do_start();
        quiet = 1'b0;
        sda_m = 1'b1;
        waitc(H/2);
        scl_m = 1'b1;
        waitc(H);
        sda_m = 1'b0;
        waitc(H);
        scl_m = 1'b0;
        waitc(H/2);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        waitc(H/2);
        scl_m = 1'b1;
        waitc(H);
        sda_m = 1'b1;
        waitc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            b[i] = s;
        end
        bit_cyc(!give_ack, s);
    endtask

    localparam logic [7:0] SEL_W = 8'hAA;  // 1010 101 0
    localparam logic [7:0] SEL_R = 8'hAB;  // 1010 101 1

    initial begin
        logic       a;
        logic [7:0] d;
        int         c0;
        waitc(5);
        // R11: reset values
        check(sda_pull == 1'b0, "R11 sda_pull in reset", sda_pull, 0);
        check(ram_we == 1'b0, "R11 ram_we in reset", ram_we, 0);
        check(commit == 1'b0, "R11 commit in reset", commit, 0);
        check(ram_addr == '0, "R11 counter in reset", int'(ram_addr), 0);
        rst_n = 1'b1;
        waitc(10);
        check(ram_addr == '0, "R11 counter after reset", int'(ram_addr), 0);

        // byte write, high address bits don't care
        c0 = n_commit;
        do_start();
        send_byte(SEL_W, a); check(a, "R1 select ack", a, 1);
        send_byte(8'hE0, a); check(a, "R3 addr high ack", a, 1);
        send_byte(8'hA5, a); check(a, "R3 addr low ack", a, 1);
        wq.push_back({13'h00A5, 8'h3C});
        send_byte(8'h3C, a); check(a, "R4 data ack", a, 1);
        do_stop(); waitc(4);
        check(n_commit == c0 + 1, "R9 commit after write", n_commit - c0, 1);

        // page write with in-page wrap
        c0 = n_commit;
        do_start();
        send_byte(SEL_W, a); send_byte(8'h01, a); send_byte(8'hFE, a);
        wq.push_back({13'h01FE, 8'h11});
        wq.push_back({13'h01FF, 8'h22});
        wq.push_back({13'h01E0, 8'h33});
        send_byte(8'h11, a); check(a, "R4 page byte 0 ack", a, 1);
        send_byte(8'h22, a); send_byte(8'h33, a);
        check(a, "R4 page byte wrap ack", a, 1);
        do_stop(); waitc(4);
        check(wq.size() == 0, "R4 page writes seen", wq.size(), 0);
        check(n_commit == c0 + 1, "R9 commit after page", n_commit - c0, 1);

        // strap mismatch
        c0 = n_commit;
        do_start(); quiet = 1'b1;
        send_byte(8'hA8, a); check(!a, "R1 strap mismatch no ack", a, 0);
        send_byte(8'h00, a); send_byte(8'h10, a); send_byte(8'h77, a);
        check(!a, "R2 ignored after mismatch", a, 0);
        do_stop(); waitc(4);
        check(n_commit == c0, "R2 no commit after mismatch", n_commit - c0, 0);

        // wrong type nibble
        do_start(); quiet = 1'b1;
        send_byte(8'hBA, a); check(!a, "R1 type mismatch no ack", a, 0);
        do_stop(); waitc(4);

        // inhibit raised during second address byte
        c0 = n_commit;
        do_start();
        send_byte(SEL_W, a); send_byte(8'h00, a);
        wr_inhibit = 1'b1;
        send_byte(8'h40, a); check(a, "R5 address still acked", a, 1);
        wr_inhibit = 1'b0;
        send_byte(8'h99, a); check(!a, "R5 data NoAck", a, 0);
        send_byte(8'h98, a); check(!a, "R5 second data NoAck", a, 0);
        do_stop(); waitc(4);
        check(n_commit == c0, "R5 no commit when inhibited", n_commit - c0, 0);

        // random read of 0x0040 shows unchanged content
        do_start();
        send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'h40, a);
        do_start();
        send_byte(SEL_R, a); check(a, "R6 read select ack", a, 1);
        recv_byte(1'b0, d);
        check(d == init_val(8'h40), "R5 inhibited location unchanged", d, init_val(8'h40));
        quiet = 1'b1; do_stop(); waitc(4);

        // random read with inhibit high, no commit
        c0 = n_commit;
        wr_inhibit = 1'b1;
        do_start();
        send_byte(SEL_W, a); send_byte(8'h00, a); send_byte(8'hA5, a);
        do_start();
        send_byte(SEL_R, a);
        recv_byte(1'b0, d);
        check(d == 8'h3C, "R6 random read data", d, 8'h3C);
        quiet = 1'b1; do_stop(); waitc(4);
        check(n_commit == c0, "R9 no commit after read", n_commit - c0, 0);

        // current-address read (counter advanced to 0x00A6), inhibit still high
        do_start();
        send_byte(SEL_R, a); check(a, "R7 current read ack", a, 1);
        recv_byte(1'b0, d);
        check(d == init_val(8'hA6), "R7 current address data", d, init_val(8'hA6));
        quiet = 1'b1; do_stop(); waitc(4);
        wr_inhibit = 1'b0;

        // sequential read across a page boundary
        do_start();
        send_byte(SEL_W, a); send_byte(8'h01, a); send_byte(8'hFE, a);
        do_start();
        send_byte(SEL_R, a);
        recv_byte(1'b1, d); check(d == 8'h11, "R8 seq byte 0", d, 8'h11);
        recv_byte(1'b1, d); check(d == 8'h22, "R8 seq byte 1", d, 8'h22);
        recv_byte(1'b0, d);
        check(d == init_val(16'h0200), "R7 full-array step", d, init_val(16'h0200));
        quiet = 1'b1;
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R8 released after NoAck", d, 8'hFF);
        do_stop(); waitc(4);

        check(wq.size() == 0, "R4 no pending writes", wq.size(), 0);
        check(prev_pull == 1'b0, "R10 bus released at end", prev_pull, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule